// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the instruction sequencer of a small 16-bit processor and handles the hardware part of interrupt service. It watches a device request. The request carries an enable bit, a 3-bit priority and an 8-bit vector. The block decides whether the request may be taken. When it is taken, the block runs a fixed multi-cycle entry sequence. The sequence moves onto the supervisor stack, pushes the status word and the program counter, and loads a new program counter from a vector table in memory. The new status word is privileged, carries the device priority and has its condition codes cleared.

When the instruction sequencer executes a return-from-interrupt, it raises `rti_req` and the block runs the reverse sequence. It pops the program counter and then the status word. If the popped status word shows user mode, it parks the supervisor stack pointer and restores the user stack pointer. A return attempted in user mode is refused and flagged as a privilege violation. The block keeps the two parked stack pointers internally. It reaches the register-file stack pointer (R6), the PC and the status register through read values and write strobes. It reaches memory through a single port whose read data returns in the same cycle.

State machine. The states are:

- IDLE: waiting.
- ENT_SWAP: stack switch on entry.
- ENT_PSR: push the status word.
- ENT_PC: push the PC.
- ENT_VEC: vector fetch and new status word.
- RET_PC: pop the PC.
- RET_PSR: pop the status word.
- RET_SWAP: stack restore and completion pulse.
- RET_FAULT: privilege violation.

The transitions are:

- IDLE goes to RET_FAULT or to RET_PC on a return request, depending on the current privilege bit.
- IDLE goes to ENT_SWAP on an accepted interrupt.
- The entry states run ENT_SWAP, ENT_PSR, ENT_PC, ENT_VEC and then back to IDLE.
- The return states run RET_PC, RET_PSR, RET_SWAP and then back to IDLE.
- RET_FAULT goes back to IDLE.

Top module: `intr_seq`

## Requirements
- R1: A request is taken, with `irq_ack` high in that same cycle, only while idle and only when `irq_req`, `irq_en` and `instr_done` are all 1 and `irq_prio` is strictly greater than status bits 10:8. Otherwise nothing is written.
- R2: On entry from user mode (status bit 15 = 1), the current R6 is parked as the user stack pointer and R6 is loaded with the parked supervisor stack pointer. The supervisor stack pointer resets to 0x3000.
- R3: Pushes pre-decrement R6. The status word is written at base-1 and the PC at base-2, and R6 ends at base-2.
- R4: The new PC is the memory word at address 0x0100 + vector (vector 0x00..0xFF).
- R5: The new status word has bit 15 = 0, bits 10:8 = the device priority and bits 2:0 = 0. All other bits are kept.
- R6: `busy` is 0 when idle. It is 1 for exactly 4 cycles after an accepted request (the last of them is the vector fetch), 3 cycles for a return and 1 cycle for a refused return.
- R7: A return reads the PC at R6 and then the status word at R6+1, and leaves R6 2 higher.
- R8: If the popped status bit 15 is 1, the post-pop R6 is parked as the supervisor stack pointer and R6 is restored from the parked user stack pointer. Otherwise R6 keeps the post-pop value. `rti_done` pulses once at the end of the return.
- R9: A return requested while status bit 15 = 1 pulses `priv_viol` for one cycle and writes no register or memory.
- R10: An interrupt taken while already in supervisor mode does no stack switch and pushes onto the current R6.
- R11: A return request in the same cycle as an acceptable interrupt takes precedence, and the interrupt is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Device requests service |
| irq_en | input | 1 | Device interrupt-enable bit |
| irq_prio | input | 3 | Device priority |
| irq_vec | input | 8 | Device vector |
| instr_done | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Return-from-interrupt being executed |
| sp_in | input | 16 | Current R6 |
| sp_we | output | 1 | Write strobe for R6 |
| sp_wdata | output | 16 | New R6 value |
| pc_in | input | 16 | Current PC |
| pc_we | output | 1 | Write strobe for PC |
| pc_wdata | output | 16 | New PC value |
| psr_in | input | 16 | Current status word |
| psr_we | output | 1 | Write strobe for status word |
| psr_wdata | output | 16 | New status word |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress; the instruction sequencer stalls |
| irq_ack | output | 1 | Request accepted this cycle |
| priv_viol | output | 1 | Return refused in user mode |
| rti_done | output | 1 | Return sequence complete |

## Verification
The assertions assume several things about the environment:

- Memory answers a read in the same cycle.
- The register file applies the `sp_we`, `pc_we` and `psr_we` writes at the next edge, so `sp_in` and `psr_in` track what the block wrote.
- `rti_req` is raised only by a completed instruction while the block is idle.

The stimulus holds every request for exactly one cycle and waits for `busy` to fall before the next one. The bench owns the register file and memory, so those write-back assumptions hold by construction. The stacks are placed in memory so that they never overlap the vector table.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ENT_SWAP,
        SQ_ENT_PSR,
        SQ_ENT_PC,
        SQ_ENT_VEC,
        SQ_RET_PC,
        SQ_RET_PSR,
        SQ_RET_SWAP,
        SQ_RET_FAULT
    } seq_state_e;

endpackage

// File: rtl/intr_accept_gate.sv
module intr_accept_gate #(
    parameter int PRIO_W = 3
) (
    input  logic              idle,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              instr_done,
    input  logic              rti_req,
    output logic              take_irq,
    output logic              take_rti
);

    logic prio_wins;
    logic irq_ready;

    always_comb begin
        prio_wins = (irq_prio > cur_prio);
        irq_ready = irq_req && irq_en && instr_done && prio_wins;
        // a return request outranks a device request in the same cycle (R11)
        take_rti  = idle && rti_req;
        take_irq  = idle && !rti_req && irq_ready;
    end

endmodule

// File: rtl/intr_shadow_sp.sv
module intr_shadow_sp #(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] SSP_RESET = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_usp,
    input  logic              park_ssp,
    input  logic [DATA_W-1:0] sp_in,
    output logic [DATA_W-1:0] usp_q,
    output logic [DATA_W-1:0] ssp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usp_q <= '0;
            ssp_q <= SSP_RESET;
        end else begin
            if (park_usp) begin
                usp_q <= sp_in;
            end
            if (park_ssp) begin
                ssp_q <= sp_in;
            end
        end
    end

endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                PRIO_W   = 3,
    parameter int                PRIO_LSB = 8,
    parameter int                CC_W     = 3,
    parameter int                VEC_W    = 8,
    parameter logic [DATA_W-1:0] VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_irq,
    input  logic              take_rti,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] psr_in,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] usp_q,
    input  logic [DATA_W-1:0] ssp_q,
    output logic              park_usp,
    output logic              park_ssp,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_wdata,
    output logic              psr_we,
    output logic [DATA_W-1:0] psr_wdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              priv_viol,
    output logic              rti_done
);

    localparam int PRIV_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    seq_state_e        st_q;
    seq_state_e        st_d;
    logic [DATA_W-1:0] lat_psr_q;
    logic [DATA_W-1:0] lat_pc_q;
    logic [PRIO_W-1:0] lat_prio_q;
    logic [VEC_W-1:0]  lat_vec_q;
    logic              ret_user_q;
    logic [DATA_W-1:0] entry_psr;
    logic [DATA_W-1:0] vec_addr;
    logic [DATA_W-1:0] sp_dec;
    logic [DATA_W-1:0] sp_inc;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (take_rti) begin
                    st_d = psr_in[PRIV_BIT] ? SQ_RET_FAULT : SQ_RET_PC;
                end else if (take_irq) begin
                    st_d = SQ_ENT_SWAP;
                end
            end
            SQ_ENT_SWAP:  st_d = SQ_ENT_PSR;
            SQ_ENT_PSR:   st_d = SQ_ENT_PC;
            SQ_ENT_PC:    st_d = SQ_ENT_VEC;
            SQ_ENT_VEC:   st_d = SQ_IDLE;
            SQ_RET_PC:    st_d = SQ_RET_PSR;
            SQ_RET_PSR:   st_d = SQ_RET_SWAP;
            SQ_RET_SWAP:  st_d = SQ_IDLE;
            SQ_RET_FAULT: st_d = SQ_IDLE;
            default:      st_d = SQ_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= SQ_IDLE;
            lat_psr_q  <= '0;
            lat_pc_q   <= '0;
            lat_prio_q <= '0;
            lat_vec_q  <= '0;
            ret_user_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && !take_rti && take_irq) begin
                lat_psr_q  <= psr_in;
                lat_pc_q   <= pc_in;
                lat_prio_q <= irq_prio;
                lat_vec_q  <= irq_vec;
            end
            if (st_q == SQ_RET_PSR) begin
                ret_user_q <= mem_rdata[PRIV_BIT];
            end
        end
    end

    // derived values
    always_comb begin
        entry_psr                          = lat_psr_q;
        entry_psr[PRIV_BIT]                = 1'b0;
        entry_psr[PRIO_LSB +: PRIO_W]      = lat_prio_q;
        entry_psr[CC_W-1:0]                = '0;
        vec_addr = VEC_BASE + {{(DATA_W-VEC_W){1'b0}}, lat_vec_q};
        sp_dec   = sp_in - ONE;
        sp_inc   = sp_in + ONE;
    end

    // outputs
    always_comb begin
        park_usp  = 1'b0;
        park_ssp  = 1'b0;
        sp_we     = 1'b0;
        sp_wdata  = sp_in;
        pc_we     = 1'b0;
        pc_wdata  = pc_in;
        psr_we    = 1'b0;
        psr_wdata = psr_in;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = (st_q != SQ_IDLE);
        priv_viol = 1'b0;
        rti_done  = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
            end
            SQ_ENT_SWAP: begin
                // switch stacks only when leaving user mode (R2, R10)
                if (lat_psr_q[PRIV_BIT]) begin
                    park_usp = 1'b1;
                    sp_we    = 1'b1;
                    sp_wdata = ssp_q;
                end
            end
            SQ_ENT_PSR: begin
                sp_we     = 1'b1;
                sp_wdata  = sp_dec;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = lat_psr_q;
            end
            SQ_ENT_PC: begin
                sp_we     = 1'b1;
                sp_wdata  = sp_dec;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = lat_pc_q;
            end
            SQ_ENT_VEC: begin
                mem_re    = 1'b1;
                mem_addr  = vec_addr;
                pc_we     = 1'b1;
                pc_wdata  = mem_rdata;
                psr_we    = 1'b1;
                psr_wdata = entry_psr;
            end
            SQ_RET_PC: begin
                mem_re   = 1'b1;
                mem_addr = sp_in;
                pc_we    = 1'b1;
                pc_wdata = mem_rdata;
                sp_we    = 1'b1;
                sp_wdata = sp_inc;
            end
            SQ_RET_PSR: begin
                mem_re    = 1'b1;
                mem_addr  = sp_in;
                psr_we    = 1'b1;
                psr_wdata = mem_rdata;
                sp_we     = 1'b1;
                sp_wdata  = sp_inc;
            end
            SQ_RET_SWAP: begin
                rti_done = 1'b1;
                if (ret_user_q) begin
                    park_ssp = 1'b1;
                    sp_we    = 1'b1;
                    sp_wdata = usp_q;
                end
            end
            SQ_RET_FAULT: begin
                priv_viol = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
    parameter int                DATA_W    = 16,
    parameter int                PRIO_W    = 3,
    parameter int                PRIO_LSB  = 8,
    parameter int                CC_W      = 3,
    parameter int                VEC_W     = 8,
    parameter logic [DATA_W-1:0] VEC_BASE  = 16'h0100,
    parameter logic [DATA_W-1:0] SSP_RESET = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              instr_done,
    input  logic              rti_req,
    input  logic [DATA_W-1:0] sp_in,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata,
    input  logic [DATA_W-1:0] pc_in,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_wdata,
    input  logic [DATA_W-1:0] psr_in,
    output logic              psr_we,
    output logic [DATA_W-1:0] psr_wdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              irq_ack,
    output logic              priv_viol,
    output logic              rti_done
);

    logic              take_irq;
    logic              take_rti;
    logic              park_usp;
    logic              park_ssp;
    logic [DATA_W-1:0] usp_q;
    logic [DATA_W-1:0] ssp_q;
    logic              fsm_busy;

    intr_accept_gate #(.PRIO_W(PRIO_W)) u_gate (
        .idle       (!fsm_busy),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .irq_prio   (irq_prio),
        .cur_prio   (psr_in[PRIO_LSB +: PRIO_W]),
        .instr_done (instr_done),
        .rti_req    (rti_req),
        .take_irq   (take_irq),
        .take_rti   (take_rti)
    );

    intr_shadow_sp #(.DATA_W(DATA_W), .SSP_RESET(SSP_RESET)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .park_usp (park_usp),
        .park_ssp (park_ssp),
        .sp_in    (sp_in),
        .usp_q    (usp_q),
        .ssp_q    (ssp_q)
    );

    intr_seq_fsm #(
        .DATA_W   (DATA_W),
        .PRIO_W   (PRIO_W),
        .PRIO_LSB (PRIO_LSB),
        .CC_W     (CC_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_irq  (take_irq),
        .take_rti  (take_rti),
        .irq_prio  (irq_prio),
        .irq_vec   (irq_vec),
        .sp_in     (sp_in),
        .pc_in     (pc_in),
        .psr_in    (psr_in),
        .mem_rdata (mem_rdata),
        .usp_q     (usp_q),
        .ssp_q     (ssp_q),
        .park_usp  (park_usp),
        .park_ssp  (park_ssp),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata),
        .psr_we    (psr_we),
        .psr_wdata (psr_wdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (fsm_busy),
        .priv_viol (priv_viol),
        .rti_done  (rti_done)
    );

    assign busy    = fsm_busy;
    assign irq_ack = take_irq;

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              irq_ack,
    input logic              priv_viol,
    input logic              rti_done,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              sp_we,
    input logic [DATA_W-1:0] sp_wdata,
    input logic              pc_we,
    input logic              psr_we,
    input logic [DATA_W-1:0] psr_wdata
);

    // R1: a request is only taken while idle
    assert_ack_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !busy);

    // R6: acceptance starts a busy period
    assert_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> busy);

    // R3: every push lands at the new stack pointer
    assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sp_we && mem_addr == sp_wdata));

    // R4: the vector fetch reads inside the table page
    assert_vec_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && psr_we) |-> (mem_addr[DATA_W-1:8] == 8'h01));

    // R5: the entry status word is privileged with cleared condition codes
    assert_entry_psr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && psr_we) |-> (!psr_wdata[DATA_W-1] && psr_wdata[2:0] == 3'b000));

    // R9: a refused return writes nothing
    assert_viol_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> !(sp_we || pc_we || psr_we || mem_we));

    // R11: acknowledge, refusal and completion never coincide
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_ack, priv_viol, rti_done}));

    // R8: completion pulse is followed by idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rti_done |=> !busy);

endmodule

bind intr_seq intr_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq_ack   (irq_ack),
    .priv_viol (priv_viol),
    .rti_done  (rti_done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_we     (sp_we),
    .sp_wdata  (sp_wdata),
    .pc_we     (pc_we),
    .psr_we    (psr_we),
    .psr_wdata (psr_wdata)
);

// File: tb/tb_intr_seq.sv
`timescale 1ns/1ps
module tb_intr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_en = 1'b0;
    logic [2:0]  irq_prio = '0;
    logic [7:0]  irq_vec = '0;
    logic        instr_done = 1'b0;
    logic        rti_req = 1'b0;
    logic [15:0] r6, pc, psr;
    logic        sp_we, pc_we, psr_we, mem_re, mem_we;
    logic [15:0] sp_wdata, pc_wdata, psr_wdata, mem_addr, mem_wdata, mem_rdata;
    logic        busy, irq_ack, priv_viol, rti_done;
    logic [15:0] mem [0:4095];

    int n_chk = 0;
    int n_bad = 0;
    int n_viol = 0;
    int n_done = 0;
    bit finished = 0;

    // model state
    logic [15:0] m_r6, m_pc, m_psr, m_usp, m_ssp;

    always #4 clk = ~clk;

    intr_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .irq_prio(irq_prio), .irq_vec(irq_vec), .instr_done(instr_done),
        .rti_req(rti_req), .sp_in(r6), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .pc_in(pc), .pc_we(pc_we), .pc_wdata(pc_wdata), .psr_in(psr),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .irq_ack(irq_ack),
        .priv_viol(priv_viol), .rti_done(rti_done)
    );

    function automatic logic [15:0] vtab(input logic [7:0] v);
        return 16'h4000 + 16'(v) * 16'd3;
    endfunction

    // register file and memory owned by the bench
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            r6  <= 16'h2F00;
            pc  <= 16'h0500;
            psr <= 16'h8102;
            for (int i = 0; i < 4096; i++)
                mem[i] <= (i >= 256 && i < 512) ? vtab(8'(i - 256)) : 16'h0000;
        end else begin
            if (sp_we)  r6  <= sp_wdata;
            if (pc_we)  pc  <= pc_wdata;
            if (psr_we) psr <= psr_wdata;
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_viol += int'(priv_viol);
            n_done += int'(rti_done);
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " r6"}, r6, m_r6);
        chk({tag, " pc"}, pc, m_pc);
        chk({tag, " psr"}, psr, m_psr);
    endtask

    // run busy window: N busy cycles, checked on every clock (R6)
    task automatic watch_busy(input int nb);
        @(negedge clk);
        irq_req = 0; rti_req = 0; instr_done = 0;
        chk("R6 busy", {15'd0, busy}, {15'd0, nb >= 1});
        for (int k = 2; k <= nb + 1; k++) begin
            @(negedge clk);
            chk("R6 busy", {15'd0, busy}, {15'd0, k <= nb});
        end
    endtask

    task automatic do_irq(input string tag, input logic en, input logic [2:0] pr,
                          input logic [7:0] v, input logic done, input logic with_rti);
        logic acc;
        logic user;
        logic [15:0] base;
        int v0, d0;
        acc = !with_rti && en && done && (pr > m_psr[10:8]);
        v0 = n_viol; d0 = n_done;
        @(negedge clk);
        irq_req = 1; irq_en = en; irq_prio = pr; irq_vec = v;
        instr_done = done; rti_req = with_rti;
        #1 chk({tag, " ack"}, {15'd0, irq_ack}, {15'd0, acc});
        @(posedge clk);
        if (with_rti) watch_busy(m_psr[15] ? 1 : 3);
        else watch_busy(acc ? 4 : 0);
        if (acc) begin
            user = m_psr[15];
            base = user ? m_ssp : m_r6;
            if (user) m_usp = m_r6;
            chk({tag, " R3 psr push"}, mem[12'(base - 16'd1)], m_psr);
            chk({tag, " R3 pc push"}, mem[12'(base - 16'd2)], m_pc);
            m_r6  = base - 16'd2;
            m_pc  = vtab(v);
            m_psr = (m_psr & 16'h78F8) | {5'd0, pr, 8'd0};
        end
        if (with_rti) chk({tag, " R9 viol pulses"}, 16'(n_viol - v0), 16'd1);
        check_regs(tag);
    endtask

    task automatic do_rti(input string tag);
        logic [15:0] npc, npsr, sp2;
        int d0, v0;
        d0 = n_done; v0 = n_viol;
        npc  = mem[m_r6[11:0]];
        npsr = mem[12'(m_r6 + 16'd1)];
        @(negedge clk);
        rti_req = 1; instr_done = 1;
        #1 chk({tag, " R11 no ack"}, {15'd0, irq_ack}, 16'd0);
        @(posedge clk);
        watch_busy(m_psr[15] ? 1 : 3);
        if (m_psr[15]) begin
            chk({tag, " R9 viol"}, 16'(n_viol - v0), 16'd1);
        end else begin
            sp2 = m_r6 + 16'd2;
            m_pc = npc; m_psr = npsr;
            if (npsr[15]) begin m_ssp = sp2; m_r6 = m_usp; end
            else m_r6 = sp2;
            chk({tag, " R8 done pulse"}, 16'(n_done - d0), 16'd1);
        end
        check_regs(tag);
    endtask

    initial begin
        m_r6 = 16'h2F00; m_pc = 16'h0500; m_psr = 16'h8102;
        m_usp = 16'h0000; m_ssp = 16'h3000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset busy R6", {15'd0, busy}, 16'd0);
        chk("reset viol R9", {15'd0, priv_viol}, 16'd0);
        chk("reset done R8", {15'd0, rti_done}, 16'd0);
        check_regs("reset");
        do_irq("R1 disabled", 1'b0, 3'd5, 8'h10, 1'b1, 1'b0);
        do_irq("R1 equal prio", 1'b1, 3'd1, 8'h10, 1'b1, 1'b0);
        do_irq("R1 lower prio", 1'b1, 3'd0, 8'h10, 1'b1, 1'b0);
        do_irq("R1 not done", 1'b1, 3'd4, 8'h10, 1'b0, 1'b0);
        do_irq("R11 rti wins R9", 1'b1, 3'd6, 8'h10, 1'b1, 1'b1);
        do_irq("R2 R4 R5 user entry", 1'b1, 3'd3, 8'h05, 1'b1, 1'b0);
        do_irq("R10 nested vec FF", 1'b1, 3'd6, 8'hFF, 1'b1, 1'b0);
        do_irq("R1 masked nested", 1'b1, 3'd2, 8'h20, 1'b1, 1'b0);
        do_rti("R7 back to supervisor");
        do_rti("R8 back to user");
        do_irq("R2 ssp restored vec 00", 1'b1, 3'd7, 8'h00, 1'b1, 1'b0);
        do_rti("R7 R8 final return");
        do_rti("R9 user rti");
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule